// File: doc/BRIEF.md
# DDR SDRAM Power-State Tracker

This block sits beside a DDR SDRAM command bus and follows, edge by edge, which power state the memory device is in. On each rising clock edge it samples the clock-enable pin and the four command strobes (chip select, row strobe, column strobe, write enable). It also samples a bank-open indication that the controller supplies. The next state comes from three things taken together: the clock-enable level at the previous edge, the level at the present edge, and the command decoded at the present edge. There are five states. Two are full-power states, one with no bank open and one with at least one bank open. Three are low-power states: power-down with banks precharged, power-down with a bank open, and self refresh.

The block also polices the timing rules that surround these states. After self refresh ends, a read must wait for the delay-locked loop to relock, and only idle commands may be issued for a short exit window. The mode-register load command is allowed only while no bank is open, and it must be followed by a short quiet gap. Clock enable must not fall while a read or write still owns the data bus. The block reports each violation with a one-cycle error flag and a code that tells the violations apart. A one-cycle event pulse marks every change of state.

All outputs are registered. The values reported after edge n describe the decision made at edge n.

Top module: `pst_tracker`

## Requirements
- R1: Reset is synchronous and active high. While reset is held and on the first edge after it, state_o is 0 (idle), evt_o is 0, err_o is 0 and err_code_o is 0. The previous clock-enable level is taken as high, and every timing window is cleared: a READ issued right after reset reports no error even if self refresh had just been left.
- R2: Commands are coded as {cs_n,ras_n,cas_n,we_n}. DESELECT is any code with cs_n=1, and NOP is 0111. From state 0 (idle) or 1 (active), clock enable going high to low with DESELECT or NOP enters state 3 (active power-down) when bank_open is 1, and state 2 (precharge power-down) when bank_open is 0.
- R3: From a full-power state, clock enable going high to low with AUTO REFRESH (0001) while bank_open is 0 enters state 4 (self refresh). With bank_open at 1, the same input is illegal and reports code 1.
- R4: In states 2, 3 and 4, clock enable low at both edges keeps the state with no error, whatever the command.
- R5: In a low-power state, clock enable going low to high with DESELECT or NOP leaves it: state 3 returns to 1, and states 2 and 4 return to 0. Any other command on that edge reports code 1 and keeps the state.
- R6: With clock enable high at both edges, a full-power state follows bank_open: 1 when it is set, 0 when it is clear. This holds even on an edge that reports an error.
- R7: During the DLL_CYC edges that start with the self-refresh exit edge, a READ (0101) reports code 2. A READ DLL_CYC edges after the exit edge is accepted.
- R8: During the XS_CYC edges that start with the self-refresh exit edge, any command other than DESELECT or NOP reports code 1. Code 2 takes precedence for a READ.
- R9: LOAD MODE REGISTER (0000) with bank_open set reports code 3. After an accepted mode-register load, any command other than DESELECT or NOP within the following MRD_CYC-1 edges also reports code 3.
- R10: Clock enable falling within RD_HOLD-1 edges after an accepted READ, or within WR_HOLD-1 edges after an accepted WRITE (0100), reports code 4 and keeps the state. At exactly RD_HOLD or WR_HOLD edges the fall is accepted.
- R11: Every other combination reports code 1 and keeps the state. This covers clock enable low at the previous edge while in a full-power state, clock enable high at the previous edge while in a low-power state, and a falling clock enable with any command other than DESELECT, NOP or AUTO REFRESH.
- R12: evt_o is 1 for exactly the cycle after an edge at which state_o changed. err_o is 1 for exactly the cycle after an edge that raised an error, and err_code_o is nonzero in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_open | input | 1 | High when at least one bank is open |
| state_o | output | 3 | Power state: 0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self refresh |
| evt_o | output | 1 | One-cycle pulse after a state change |
| err_o | output | 1 | One-cycle pulse after an erroneous edge |
| err_code_o | output | 3 | 0 none, 1 illegal, 2 early read, 3 mode-register rule, 4 clock enable dropped during access |

## Verification
Two pairs of checks can fire on the same edge. Just after self refresh ends, the relock rule and the exit-window rule both cover a READ. The bench issues a READ on the second edge after the exit and expects the early-read code, not the generic illegal code. A WRITE on the next edge then shows the exit-window rule acting alone. The second pair is error reporting and state tracking. An illegal ACTIVATE or mode-register load is issued while bank_open changes. The bench expects the error code and also the state that bank_open calls for, in the same cycle.

// File: rtl/pst_pkg.sv
package pst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PPD    = 3'd2,
    ST_APD    = 3'd3,
    ST_SREF   = 3'd4
  } pwr_state_e;

  typedef enum logic [2:0] {
    EC_NONE     = 3'd0,
    EC_ILLEGAL  = 3'd1,
    EC_EARLY_RD = 3'd2,
    EC_MODE_REG = 3'd3,
    EC_CKE_DROP = 3'd4
  } err_code_e;

  typedef struct packed {
    logic idle_cmd;
    logic is_read;
    logic is_write;
    logic is_ref;
    logic is_lmr;
  } cmd_dec_t;

endpackage

// File: rtl/pst_cmd_decode.sv
module pst_cmd_decode
  import pst_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output cmd_dec_t dec
);

  logic [2:0] rcw;
  assign rcw = {ras_n, cas_n, we_n};

  always_comb begin
    dec.idle_cmd = cs_n | (rcw == 3'b111);
    dec.is_read  = !cs_n && (rcw == 3'b101);
    dec.is_write = !cs_n && (rcw == 3'b100);
    dec.is_ref   = !cs_n && (rcw == 3'b001);
    dec.is_lmr   = !cs_n && (rcw == 3'b000);
  end

endmodule

// File: rtl/pst_window.sv
module pst_window #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  generate
    if (LEN > 1) begin : g_cnt
      localparam int W = $clog2(LEN);
      logic [W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (start) begin
          cnt <= W'(LEN - 1);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign busy = (cnt != '0);

      AST_WINDOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt == $past(cnt) - 1'b1)); // R8
    end else begin : g_none
      logic unused_win;
      assign unused_win = clk ^ rst ^ start;
      assign busy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pst_tracker.sv
module pst_tracker
  import pst_pkg::*;
#(
  parameter int DLL_CYC = 200,
  parameter int XS_CYC  = 10,
  parameter int MRD_CYC = 2,
  parameter int RD_HOLD = 3,
  parameter int WR_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       bank_open,
  output logic [2:0] state_o,
  output logic       evt_o,
  output logic       err_o,
  output logic [2:0] err_code_o
);

  cmd_dec_t   dec;
  pwr_state_e state_q, nxt_state;
  err_code_e  code_q, nxt_err;
  logic       cke_prev_q, evt_q, err_q;
  logic       dll_busy, xs_busy, mrd_busy, rd_busy, wr_busy;
  logic       sx_go, mrd_go, rd_go, wr_go;
  logic       full_pwr;

  pst_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dec(dec)
  );

  pst_window #(.LEN(DLL_CYC)) u_dll (.clk(clk), .rst(rst), .start(sx_go),  .busy(dll_busy));
  pst_window #(.LEN(XS_CYC))  u_xs  (.clk(clk), .rst(rst), .start(sx_go),  .busy(xs_busy));
  pst_window #(.LEN(MRD_CYC)) u_mrd (.clk(clk), .rst(rst), .start(mrd_go), .busy(mrd_busy));
  pst_window #(.LEN(RD_HOLD)) u_rd  (.clk(clk), .rst(rst), .start(rd_go),  .busy(rd_busy));
  pst_window #(.LEN(WR_HOLD)) u_wr  (.clk(clk), .rst(rst), .start(wr_go),  .busy(wr_busy));

  assign full_pwr = (state_q == ST_IDLE) || (state_q == ST_ACTIVE);

  always_comb begin
    nxt_state = state_q;
    nxt_err   = EC_NONE;
    sx_go     = 1'b0;
    mrd_go    = 1'b0;
    rd_go     = 1'b0;
    wr_go     = 1'b0;
    if (full_pwr) begin
      case ({cke_prev_q, cke})
        2'b11: begin
          nxt_state = bank_open ? ST_ACTIVE : ST_IDLE;
          if (dec.is_read && dll_busy)            nxt_err = EC_EARLY_RD;
          else if (!dec.idle_cmd && xs_busy)      nxt_err = EC_ILLEGAL;
          else if (dec.is_lmr && bank_open)       nxt_err = EC_MODE_REG;
          else if (!dec.idle_cmd && mrd_busy)     nxt_err = EC_MODE_REG;
          else begin
            rd_go  = dec.is_read;
            wr_go  = dec.is_write;
            mrd_go = dec.is_lmr;
          end
        end
        2'b10: begin
          if (rd_busy || wr_busy)                 nxt_err   = EC_CKE_DROP;
          else if (dec.idle_cmd)                  nxt_state = bank_open ? ST_APD : ST_PPD;
          else if (dec.is_ref && !bank_open)      nxt_state = ST_SREF;
          else                                    nxt_err   = EC_ILLEGAL;
        end
        default:                                  nxt_err   = EC_ILLEGAL;
      endcase
    end else begin
      case ({cke_prev_q, cke})
        2'b00: nxt_state = state_q;
        2'b01: begin
          if (dec.idle_cmd) begin
            nxt_state = (state_q == ST_APD) ? ST_ACTIVE : ST_IDLE;
            sx_go     = (state_q == ST_SREF);
          end else begin
            nxt_err = EC_ILLEGAL;
          end
        end
        default: nxt_err = EC_ILLEGAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      code_q     <= EC_NONE;
      cke_prev_q <= 1'b1;
      evt_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= nxt_state;
      code_q     <= nxt_err;
      cke_prev_q <= cke;
      evt_q      <= (nxt_state != state_q);
      err_q      <= (nxt_err != EC_NONE);
    end
  end

  assign state_o    = state_q;
  assign evt_o      = evt_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (full_pwr && cke_prev_q && !cke && dec.idle_cmd && !rd_busy && !wr_busy)
    |=> (state_q == ($past(bank_open) ? ST_APD : ST_PPD))); // R2

  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!full_pwr && !cke_prev_q && !cke) |=> ($stable(state_q) && !err_q)); // R4

  AST_APD_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_APD && !cke_prev_q && cke && dec.idle_cmd) |=> (state_q == ST_ACTIVE)); // R5

  AST_EARLY_READ: assert property (@(posedge clk) disable iff (rst)
    (full_pwr && cke_prev_q && cke && dec.is_read && dll_busy)
    |=> (err_q && code_q == EC_EARLY_RD)); // R7

  AST_CKE_DROP: assert property (@(posedge clk) disable iff (rst)
    (full_pwr && cke_prev_q && !cke && (rd_busy || wr_busy))
    |=> (code_q == EC_CKE_DROP && $stable(state_q))); // R10

  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (code_q != EC_NONE)); // R12

endmodule

// File: tb/pst_tracker_tb.sv
module pst_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DLL = 200;
  localparam int XS  = 10;
  localparam int WRH = 4;

  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_LMR = 4'b0000;
  localparam logic [2:0] S_I = 3'd0, S_A = 3'd1, S_P = 3'd2, S_AP = 3'd3, S_S = 3'd4;
  localparam logic [2:0] E_N = 3'd0, E_IL = 3'd1, E_RD = 3'd2, E_MR = 3'd3, E_DR = 3'd4;

  localparam int NV = 36;
  // {cke, cmd, bank_open, expected state, expected code}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 0  R6
    {1'b1, C_ACT, 1'b1, S_A,  E_N },  // 1  R6
    {1'b0, C_NOP, 1'b1, S_AP, E_N },  // 2  R2
    {1'b0, C_RD,  1'b1, S_AP, E_N },  // 3  R4
    {1'b1, C_NOP, 1'b1, S_A,  E_N },  // 4  R5
    {1'b1, C_PRE, 1'b0, S_I,  E_N },  // 5  R6
    {1'b0, C_DES, 1'b0, S_P,  E_N },  // 6  R2
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 7  R5
    {1'b0, C_NOP, 1'b0, S_P,  E_N },  // 8  R2
    {1'b1, C_ACT, 1'b0, S_P,  E_IL},  // 9  R5
    {1'b1, C_NOP, 1'b0, S_P,  E_IL},  // 10 R11
    {1'b0, C_NOP, 1'b0, S_P,  E_IL},  // 11 R11
    {1'b0, C_NOP, 1'b0, S_P,  E_N },  // 12 R4
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 13 R5
    {1'b1, C_LMR, 1'b1, S_A,  E_MR},  // 14 R9
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 15 R6
    {1'b1, C_LMR, 1'b0, S_I,  E_N },  // 16 R9
    {1'b1, C_ACT, 1'b1, S_A,  E_MR},  // 17 R9
    {1'b1, C_ACT, 1'b1, S_A,  E_N },  // 18 R9
    {1'b1, C_RD,  1'b1, S_A,  E_N },  // 19 R10
    {1'b0, C_NOP, 1'b1, S_A,  E_DR},  // 20 R10
    {1'b1, C_NOP, 1'b1, S_A,  E_IL},  // 21 R11
    {1'b0, C_NOP, 1'b1, S_AP, E_N },  // 22 R10
    {1'b1, C_NOP, 1'b1, S_A,  E_N },  // 23 R5
    {1'b1, C_PRE, 1'b0, S_I,  E_N },  // 24 R6
    {1'b0, C_REF, 1'b0, S_S,  E_N },  // 25 R3
    {1'b0, C_NOP, 1'b0, S_S,  E_N },  // 26 R4
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 27 R5
    {1'b1, C_ACT, 1'b1, S_A,  E_IL},  // 28 R8
    {1'b1, C_RD,  1'b1, S_A,  E_RD},  // 29 R7
    {1'b1, C_WR,  1'b1, S_A,  E_IL},  // 30 R8
    {1'b0, C_ACT, 1'b1, S_A,  E_IL},  // 31 R11
    {1'b1, C_NOP, 1'b1, S_A,  E_IL},  // 32 R11
    {1'b1, C_NOP, 1'b0, S_I,  E_N },  // 33 R6
    {1'b0, C_REF, 1'b1, S_I,  E_IL},  // 34 R3
    {1'b1, C_NOP, 1'b0, S_I,  E_IL}   // 35 R11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bank_open = 1'b0;
  logic [2:0] state_o, err_code_o;
  logic evt_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [2:0] prev_exp = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pst_tracker u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_open(bank_open), .state_o(state_o), .evt_o(evt_o),
    .err_o(err_o), .err_code_o(err_code_o)
  );

  function automatic string tag_of(input int i);
    case (i)
      2, 6, 8:                     return "R2";
      25, 34:                      return "R3";
      3, 12, 26:                   return "R4";
      4, 7, 9, 13, 23, 27:         return "R5";
      14, 16, 17, 18:              return "R9";
      19, 20, 22:                  return "R10";
      28, 30:                      return "R8";
      29:                          return "R7";
      10, 11, 21, 31, 32, 35:      return "R11";
      default:                     return "R6";
    endcase
  endfunction

  task automatic check(input logic [2:0] es, input logic [2:0] ec, input logic ee,
                       input logic ev, input string tag);
    n_run++;
    if (state_o !== es || err_code_o !== ec || err_o !== ee || evt_o !== ev) begin
      n_fail++;
      $display("FAIL %s: state=%0d exp %0d, code=%0d exp %0d, err=%0b exp %0b, evt=%0b exp %0b",
               tag, state_o, es, err_code_o, ec, err_o, ee, evt_o, ev);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c, input logic b,
                      input logic [2:0] es, input logic [2:0] ec, input string tag);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; bank_open = b;
    @(posedge clk);
    #1;
    // R12: event and error pulses derive from the expected sequence
    check(es, ec, ec != 3'd0, es != prev_exp, tag);
    prev_exp = es;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = C_NOP; bank_open = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(S_I, E_N, 1'b0, 1'b0, "R1 reset held");
    @(negedge clk);
    rst = 1'b0;
    prev_exp = S_I;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10:7], VEC[i][6], VEC[i][5:3], VEC[i][2:0], tag_of(i));
    end

    // R8: exit-window boundary
    step(1'b0, C_REF, 1'b0, S_S, E_N, "R3 sref entry");
    step(1'b1, C_NOP, 1'b0, S_I, E_N, "R5 sref exit");
    for (int k = 1; k < XS - 1; k++) step(1'b1, C_NOP, 1'b0, S_I, E_N, "R8 window nop");
    step(1'b1, C_PRE, 1'b0, S_I, E_IL, "R8 last edge of window");
    step(1'b1, C_PRE, 1'b0, S_I, E_N,  "R8 window over");

    // R7: relock boundary
    step(1'b0, C_REF, 1'b0, S_S, E_N, "R3 sref entry");
    step(1'b1, C_NOP, 1'b0, S_I, E_N, "R5 sref exit");
    for (int k = 1; k < DLL - 1; k++) step(1'b1, C_NOP, 1'b0, S_I, E_N, "R7 relock nop");
    step(1'b1, C_RD, 1'b0, S_I, E_RD, "R7 read one edge early");
    step(1'b1, C_RD, 1'b0, S_I, E_N,  "R7 read at boundary");

    // R10: write-recovery boundary
    step(1'b1, C_ACT, 1'b1, S_A, E_N, "R6 activate");
    step(1'b1, C_WR,  1'b1, S_A, E_N, "R10 write");
    for (int k = 1; k < WRH - 1; k++) step(1'b1, C_NOP, 1'b1, S_A, E_N, "R10 hold");
    step(1'b0, C_NOP, 1'b1, S_A, E_DR, "R10 cke drop early");
    step(1'b1, C_NOP, 1'b1, S_A, E_IL, "R11 low prev cke");
    step(1'b1, C_WR,  1'b1, S_A, E_N, "R10 write");
    for (int k = 1; k < WRH; k++) step(1'b1, C_NOP, 1'b1, S_A, E_N, "R10 hold");
    step(1'b0, C_NOP, 1'b1, S_AP, E_N, "R10 cke drop at boundary");
    step(1'b1, C_NOP, 1'b1, S_A, E_N, "R5 exit");

    // R1: reset clears windows and state
    step(1'b1, C_PRE, 1'b0, S_I, E_N, "R6 precharge");
    step(1'b0, C_REF, 1'b0, S_S, E_N, "R3 sref entry");
    step(1'b1, C_NOP, 1'b0, S_I, E_N, "R5 sref exit");
    do_reset();
    step(1'b1, C_RD, 1'b0, S_I, E_N, "R1 windows cleared");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule